// File: doc/BRIEF.md
# Snooping Broadcast Bus with Shared-Line Combining

This block is the shared interconnect that sits between a set of private caches and one memory port. Caches raise requests carrying a transaction kind, a line address and, for a write-back, the line data. A round-robin arbiter picks one requester and holds its grant until the transaction ends. Because of this, every transaction gets its place in a single global order. The granted transaction is broadcast for one cycle to all caches. A mask tells each cache whether it is an observer, which means every cache except the requester.

Observers answer within a fixed snoop window. Each one drives a "holds the line" flag, a "holds it dirty" flag and its copy of the data. At the end of the window the bus ORs the hit flags of the observers into a shared-line value. If an observer holds the line dirty, that cache supplies the data and the memory read, which was issued speculatively at broadcast time, is cancelled. Otherwise the data comes from memory. An upgrade moves no data and touches no memory. A write-back is forwarded to memory as a write. The requester receives a one-cycle done pulse together with the final shared-line value and the data.

Top module: `snoop_bus`

## Requirements
- R1: At most one grant bit is high at any time. Once a cache is granted, the grant stays unchanged until the cycle its done pulse ends.
- R2: Arbitration is round-robin. When several caches request at once, the winner is the first requester found at a higher index than the previous owner, wrapping around. After reset the search starts at index 0.
- R3: Each transaction is broadcast for exactly one cycle, in the first cycle of its grant. The broadcast carries the requester's kind and address. `snoop_obs` has every bit set except the requester's.
- R4: `resp_shared` is the OR of `snp_hit` over all caches other than the requester, sampled on the last cycle of the snoop window. It is low when no other cache holds the line, and the requester's own hit is ignored.
- R5: On a read (kind 0) or read-for-ownership (kind 1), if an observer asserts `snp_dirty`, the returned data is that cache's `snp_data` rather than memory data. In the done cycle `mem_rd_cancel` pulses.
- R6: On a read or read-for-ownership with no dirty observer, the returned data is the memory data from `mem_ack`. This holds even when the memory answers before the window closes.
- R7: An upgrade (kind 2) issues no memory read and no memory write.
- R8: A write-back (kind 3) drives `mem_wr_req` with the requester's address and data until `mem_ack`. The done pulse follows the acknowledge.
- R9: The done pulse lasts one cycle and goes only to the requester. For an upgrade or an intervention it arrives SNOOP_WIN+1 cycles after the cycle in which the grant first appears.
- R10: After reset there is no grant, no done pulse, no broadcast and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CACHES | Request flag per cache, held until done |
| req_type | input | 2*N_CACHES | Kind per cache: 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| req_addr | input | N_CACHES*ADDR_W | Line address per cache |
| req_wdata | input | N_CACHES*DATA_W | Write-back data per cache |
| grant | output | N_CACHES | One-hot grant, held for the whole transaction |
| snoop_valid | output | 1 | Broadcast strobe, one cycle per transaction |
| snoop_type | output | 2 | Broadcast transaction kind |
| snoop_addr | output | ADDR_W | Broadcast line address |
| snoop_obs | output | N_CACHES | Caches that must answer the broadcast |
| snp_hit | input | N_CACHES | Snoop reply: cache holds the line |
| snp_dirty | input | N_CACHES | Snoop reply: cache holds the line modified |
| snp_data | input | N_CACHES*DATA_W | Snoop reply data per cache |
| resp_done | output | N_CACHES | One-cycle completion pulse to the requester |
| resp_shared | output | 1 | Final shared-line value |
| resp_data | output | DATA_W | Returned line data |
| mem_rd_req | output | 1 | Memory read start pulse |
| mem_rd_cancel | output | 1 | Abort of the outstanding memory read |
| mem_wr_req | output | 1 | Memory write request, held until acknowledge |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory read-data-valid or write-complete pulse |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The properties are checked on every cycle:
- grant exclusivity and hold;
- the observer mask being the complement of the grant during a broadcast;
- the done pulse reaching only the owner and lasting one cycle;
- a cancel occurring only with a completion;
- upgrades never starting a memory read.

Other behaviour depends on data and on history, so only the directed scenarios can show it:
- the shared-line value with the requester's own hit ignored;
- the choice between snooped data and memory data, including an early memory answer;
- write-back address and data;
- exact completion latency;
- the rotating order among simultaneous requesters.

// File: rtl/snoop_bus_pkg.sv
package snoop_bus_pkg;

   typedef enum logic [1:0] {
      TXN_RD   = 2'd0,
      TXN_RDX  = 2'd1,
      TXN_UPGR = 2'd2,
      TXN_WB   = 2'd3
   } txn_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WIN,
      ST_MEMR,
      ST_MEMW,
      ST_RESP
   } bus_st_e;

endpackage

// File: rtl/snoop_rr_arb.sv
module snoop_rr_arb #(
   parameter int N_CACHES = 4,
   localparam int IW = $clog2(N_CACHES)
) (
   input  logic [N_CACHES-1:0] req,
   input  logic [IW-1:0]       last,
   output logic [N_CACHES-1:0] gnt,
   output logic [IW-1:0]       gnt_idx
);

   always_comb begin
      logic found;
      found   = 1'b0;
      gnt     = '0;
      gnt_idx = '0;
      for (int off = 1; off <= N_CACHES; off++) begin
         int cand;
         cand = (int'(last) + off) % N_CACHES;
         if (!found && req[cand]) begin
            found     = 1'b1;
            gnt[cand] = 1'b1;
            gnt_idx   = IW'(cand);
         end
      end
   end

endmodule

// File: rtl/snoop_reply_combine.sv
module snoop_reply_combine #(
   parameter int N_CACHES = 4,
   parameter int DATA_W   = 64
) (
   input  logic [N_CACHES-1:0]        excl,
   input  logic [N_CACHES-1:0]        hit,
   input  logic [N_CACHES-1:0]        dirty,
   input  logic [N_CACHES*DATA_W-1:0] data,
   output logic                       shared_any,
   output logic                       dirty_any,
   output logic [DATA_W-1:0]          dirty_data
);

   logic [N_CACHES-1:0] obs_hit;
   logic [N_CACHES-1:0] obs_dirty;

   for (genvar g = 0; g < N_CACHES; g++) begin : g_mask
      assign obs_hit[g]   = hit[g]   & ~excl[g];
      assign obs_dirty[g] = dirty[g] & ~excl[g];
   end

   assign shared_any = |obs_hit;
   assign dirty_any  = |obs_dirty;

   // lowest-index dirty observer wins; at most one is expected
   always_comb begin
      dirty_data = '0;
      for (int k = N_CACHES - 1; k >= 0; k--) begin
         if (obs_dirty[k]) dirty_data = data[k*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/snoop_bus.sv
module snoop_bus
   import snoop_bus_pkg::*;
#(
   parameter int N_CACHES  = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 64,
   parameter int SNOOP_WIN = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_CACHES-1:0]        req_valid,
   input  logic [2*N_CACHES-1:0]      req_type,
   input  logic [N_CACHES*ADDR_W-1:0] req_addr,
   input  logic [N_CACHES*DATA_W-1:0] req_wdata,
   output logic [N_CACHES-1:0]        grant,
   output logic                       snoop_valid,
   output logic [1:0]                 snoop_type,
   output logic [ADDR_W-1:0]          snoop_addr,
   output logic [N_CACHES-1:0]        snoop_obs,
   input  logic [N_CACHES-1:0]        snp_hit,
   input  logic [N_CACHES-1:0]        snp_dirty,
   input  logic [N_CACHES*DATA_W-1:0] snp_data,
   output logic [N_CACHES-1:0]        resp_done,
   output logic                       resp_shared,
   output logic [DATA_W-1:0]          resp_data,
   output logic                       mem_rd_req,
   output logic                       mem_rd_cancel,
   output logic                       mem_wr_req,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [DATA_W-1:0]          mem_wdata,
   input  logic                       mem_ack,
   input  logic [DATA_W-1:0]          mem_rdata
);

   localparam int IW  = $clog2(N_CACHES);
   localparam int WCW = $clog2(SNOOP_WIN + 1);
   localparam logic [WCW-1:0] WIN_LAST = WCW'(SNOOP_WIN - 1);
   localparam logic [IW-1:0]  IDX_TOP  = IW'(N_CACHES - 1);

   if (N_CACHES < 2) begin : g_bad_n
      $error("snoop_bus: N_CACHES must be at least 2");
   end
   if (SNOOP_WIN < 1) begin : g_bad_win
      $error("snoop_bus: SNOOP_WIN must be at least 1");
   end

   bus_st_e             state_q;
   logic [N_CACHES-1:0] grant_q;
   logic [IW-1:0]       owner_q;
   logic [IW-1:0]       last_q;
   txn_e                kind_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [WCW-1:0]      win_cnt;
   logic                shared_q;
   logic                interv_q;
   logic [DATA_W-1:0]   data_q;
   logic                mem_got;
   logic [DATA_W-1:0]   mem_buf;

   logic [N_CACHES-1:0] arb_gnt;
   logic [IW-1:0]       arb_idx;
   logic                cmb_shared;
   logic                cmb_dirty;
   logic [DATA_W-1:0]   cmb_data;

   snoop_rr_arb #(.N_CACHES(N_CACHES)) u_arb (
      .req     (req_valid),
      .last    (last_q),
      .gnt     (arb_gnt),
      .gnt_idx (arb_idx)
   );

   snoop_reply_combine #(.N_CACHES(N_CACHES), .DATA_W(DATA_W)) u_comb (
      .excl       (grant_q),
      .hit        (snp_hit),
      .dirty      (snp_dirty),
      .data       (snp_data),
      .shared_any (cmb_shared),
      .dirty_any  (cmb_dirty),
      .dirty_data (cmb_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         grant_q  <= '0;
         owner_q  <= '0;
         last_q   <= IDX_TOP;
         kind_q   <= TXN_RD;
         addr_q   <= '0;
         wdata_q  <= '0;
         win_cnt  <= '0;
         shared_q <= 1'b0;
         interv_q <= 1'b0;
         data_q   <= '0;
         mem_got  <= 1'b0;
         mem_buf  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (|req_valid) begin
                  grant_q  <= arb_gnt;
                  owner_q  <= arb_idx;
                  kind_q   <= txn_e'(req_type[int'(arb_idx)*2 +: 2]);
                  addr_q   <= req_addr[int'(arb_idx)*ADDR_W +: ADDR_W];
                  wdata_q  <= req_wdata[int'(arb_idx)*DATA_W +: DATA_W];
                  mem_got  <= 1'b0;
                  interv_q <= 1'b0;
                  shared_q <= 1'b0;
                  state_q  <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               win_cnt <= '0;
               state_q <= (kind_q == TXN_WB) ? ST_MEMW : ST_WIN;
            end
            ST_WIN: begin
               if (mem_ack) begin
                  mem_got <= 1'b1;
                  mem_buf <= mem_rdata;
               end
               if (win_cnt == WIN_LAST) begin
                  shared_q <= cmb_shared;
                  if (kind_q == TXN_UPGR) begin
                     state_q <= ST_RESP;
                  end else if (cmb_dirty) begin
                     interv_q <= 1'b1;
                     data_q   <= cmb_data;
                     state_q  <= ST_RESP;
                  end else if (mem_ack) begin
                     data_q  <= mem_rdata;
                     state_q <= ST_RESP;
                  end else if (mem_got) begin
                     data_q  <= mem_buf;
                     state_q <= ST_RESP;
                  end else begin
                     state_q <= ST_MEMR;
                  end
               end else begin
                  win_cnt <= win_cnt + 1'b1;
               end
            end
            ST_MEMR: begin
               if (mem_ack) begin
                  data_q  <= mem_rdata;
                  state_q <= ST_RESP;
               end
            end
            ST_MEMW: begin
               if (mem_ack) state_q <= ST_RESP;
            end
            ST_RESP: begin
               grant_q <= '0;
               last_q  <= owner_q;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign grant         = grant_q;
   assign snoop_valid   = (state_q == ST_ADDR);
   assign snoop_type    = kind_q;
   assign snoop_addr    = addr_q;
   assign snoop_obs     = snoop_valid ? ~grant_q : '0;
   assign resp_done     = (state_q == ST_RESP) ? grant_q : '0;
   assign resp_shared   = shared_q;
   assign resp_data     = data_q;
   assign mem_rd_req    = (state_q == ST_ADDR) && ((kind_q == TXN_RD) || (kind_q == TXN_RDX));
   assign mem_rd_cancel = (state_q == ST_RESP) && interv_q;
   assign mem_wr_req    = (state_q == ST_MEMW);
   assign mem_addr      = addr_q;
   assign mem_wdata     = wdata_q;

endmodule

// File: rtl/snoop_bus_chk.sv
module snoop_bus_chk #(
   parameter int N_CACHES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_CACHES-1:0] grant,
   input logic                snoop_valid,
   input logic [1:0]          snoop_type,
   input logic [N_CACHES-1:0] snoop_obs,
   input logic [N_CACHES-1:0] resp_done,
   input logic                mem_rd_req,
   input logic                mem_rd_cancel,
   input logic                mem_wr_req
);

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((|grant) && !(|resp_done)) |=> (grant == $past(grant)));

   assert_bcast_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|grant) |-> snoop_valid);

   assert_bcast_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |=> !snoop_valid);

   assert_obs_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |-> ((snoop_obs == ~grant) && $onehot(grant)));

   assert_cancel_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_cancel |-> (|resp_done));

   assert_upgr_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && snoop_type == snoop_bus_pkg::TXN_UPGR) |-> !mem_rd_req);

   assert_wr_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |-> $onehot(grant));

   assert_done_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|resp_done) |-> (resp_done == grant));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|resp_done) |=> !(|resp_done));

endmodule

bind snoop_bus snoop_bus_chk #(.N_CACHES(N_CACHES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .grant         (grant),
   .snoop_valid   (snoop_valid),
   .snoop_type    (snoop_type),
   .snoop_obs     (snoop_obs),
   .resp_done     (resp_done),
   .mem_rd_req    (mem_rd_req),
   .mem_rd_cancel (mem_rd_cancel),
   .mem_wr_req    (mem_wr_req)
);

// File: tb/tb_snoop_bus.sv
`timescale 1ns/1ps
module tb_snoop_bus;

   localparam int N  = 4;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req_valid = '0;
   logic [2*N-1:0]    req_type = '0;
   logic [N*AW-1:0]   req_addr = '0;
   logic [N*DW-1:0]   req_wdata = '0;
   logic [N-1:0]      grant;
   logic              snoop_valid;
   logic [1:0]        snoop_type;
   logic [AW-1:0]     snoop_addr;
   logic [N-1:0]      snoop_obs;
   logic [N-1:0]      snp_hit = '0;
   logic [N-1:0]      snp_dirty = '0;
   logic [N*DW-1:0]   snp_data = '0;
   logic [N-1:0]      resp_done;
   logic              resp_shared;
   logic [DW-1:0]     resp_data;
   logic              mem_rd_req, mem_rd_cancel, mem_wr_req;
   logic [AW-1:0]     mem_addr;
   logic [DW-1:0]     mem_wdata;
   logic              mem_ack = 1'b0;
   logic [DW-1:0]     mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   snoop_bus #(.N_CACHES(N), .ADDR_W(AW), .DATA_W(DW), .SNOOP_WIN(W)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
      .grant(grant), .snoop_valid(snoop_valid), .snoop_type(snoop_type),
      .snoop_addr(snoop_addr), .snoop_obs(snoop_obs),
      .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data),
      .resp_done(resp_done), .resp_shared(resp_shared), .resp_data(resp_data),
      .mem_rd_req(mem_rd_req), .mem_rd_cancel(mem_rd_cancel), .mem_wr_req(mem_wr_req),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] mem_pat(input logic [AW-1:0] a);
      return {a ^ 16'h5EED, a};
   endfunction

   // memory model
   int            mem_lat = 4;
   int            n_rd = 0, n_wr = 0, n_cancel = 0;
   logic          rd_pend = 0, wr_busy = 0, wr_acked = 0;
   int            rd_ctr = 0, wr_ctr = 0;
   logic [AW-1:0] rd_addr_l = '0, wr_addr_seen = '0;
   logic [DW-1:0] wr_data_seen = '0;

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_rd_cancel) begin
         rd_pend  <= 1'b0;
         n_cancel <= n_cancel + 1;
      end
      if (mem_rd_req) begin
         n_rd      <= n_rd + 1;
         rd_pend   <= 1'b1;
         rd_ctr    <= mem_lat;
         rd_addr_l <= mem_addr;
      end else if (rd_pend && !mem_rd_cancel) begin
         if (rd_ctr == 0) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_pat(rd_addr_l);
            rd_pend   <= 1'b0;
         end else rd_ctr <= rd_ctr - 1;
      end
      if (mem_wr_req) begin
         if (!wr_busy) begin
            wr_busy      <= 1'b1;
            n_wr         <= n_wr + 1;
            wr_addr_seen <= mem_addr;
            wr_data_seen <= mem_wdata;
            wr_ctr       <= mem_lat;
         end else if (!wr_acked) begin
            if (wr_ctr == 0) begin
               mem_ack  <= 1'b1;
               wr_acked <= 1'b1;
            end else wr_ctr <= wr_ctr - 1;
         end
      end else begin
         wr_busy  <= 1'b0;
         wr_acked <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one transaction from one cache; returns shared, data, latency
   task automatic do_txn(input int src, input logic [1:0] typ, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, output logic sh, output logic [DW-1:0] d,
                         output int lat);
      bit seen_g = 0;
      int n_bc = 0;
      @(negedge clk);
      req_type[src*2 +: 2]   = typ;
      req_addr[src*AW +: AW] = addr;
      req_wdata[src*DW +: DW] = wd;
      req_valid[src]         = 1'b1;
      lat = 0;
      forever begin
         @(negedge clk);
         if (seen_g) lat++;
         if (!seen_g && grant[src]) seen_g = 1;
         if (snoop_valid && grant[src]) begin
            n_bc++;
            chk(snoop_type == typ, "R3 bcast type", 64'(snoop_type), 64'(typ));
            chk(snoop_addr == addr, "R3 bcast addr", 64'(snoop_addr), 64'(addr));
            chk(snoop_obs == ~(N'(1) << src), "R3 observer mask", 64'(snoop_obs), 64'(~(N'(1) << src)));
         end
         if (|resp_done) begin
            chk(resp_done == (N'(1) << src), "R9 done to requester", 64'(resp_done), 64'(N'(1) << src));
            sh = resp_shared;
            d  = resp_data;
            req_valid[src] = 1'b0;
            break;
         end
      end
      chk(n_bc == 1, "R3 one broadcast", 64'(n_bc), 64'd1);
      @(negedge clk);
      chk(resp_done == '0, "R9 done one cycle", 64'(resp_done), 64'd0);
   endtask

   task automatic t_reset();
      chk(grant == '0, "R10 grant", 64'(grant), 64'd0);
      chk(resp_done == '0, "R10 done", 64'(resp_done), 64'd0);
      chk(!snoop_valid && !mem_rd_req && !mem_wr_req, "R10 idle outputs",
          64'({snoop_valid, mem_rd_req, mem_wr_req}), 64'd0);
   endtask

   task automatic t_rd_alone();
      logic sh; logic [DW-1:0] d; int lat; int r0;
      snp_hit = 4'b0001; snp_dirty = '0;   // only the requester itself holds it
      r0 = n_rd;
      do_txn(0, 2'd0, 16'h0100, '0, sh, d, lat);
      chk(sh == 1'b0, "R4 shared low, own hit ignored", 64'(sh), 64'd0);
      chk(d == mem_pat(16'h0100), "R6 data from memory", 64'(d), 64'(mem_pat(16'h0100)));
      chk(n_rd == r0 + 1, "R6 one memory read", 64'(n_rd), 64'(r0 + 1));
   endtask

   task automatic t_rd_shared();
      logic sh; logic [DW-1:0] d; int lat;
      snp_hit = 4'b1000; snp_dirty = '0;
      do_txn(1, 2'd0, 16'h0240, '0, sh, d, lat);
      chk(sh == 1'b1, "R4 shared high", 64'(sh), 64'd1);
      chk(d == mem_pat(16'h0240), "R6 data from memory (shared)", 64'(d), 64'(mem_pat(16'h0240)));
   endtask

   task automatic t_intervene();
      logic sh; logic [DW-1:0] d; int lat; int c0;
      snp_hit = 4'b0001; snp_dirty = 4'b0001;
      snp_data = '0;
      snp_data[0*DW +: DW] = 32'hD1E7_0A0A;
      c0 = n_cancel;
      do_txn(2, 2'd1, 16'h0380, '0, sh, d, lat);
      chk(d == 32'hD1E7_0A0A, "R5 data from dirty owner", 64'(d), 64'hD1E70A0A);
      chk(lat == W + 1, "R9 intervention latency", 64'(lat), 64'(W + 1));
      @(negedge clk);
      chk(n_cancel == c0 + 1, "R5 memory read cancelled", 64'(n_cancel), 64'(c0 + 1));
      snp_dirty = '0; snp_hit = '0;
   endtask

   task automatic t_upgr();
      logic sh; logic [DW-1:0] d; int lat; int r0; int w0;
      snp_hit = 4'b0010;
      r0 = n_rd; w0 = n_wr;
      do_txn(3, 2'd2, 16'h04C0, '0, sh, d, lat);
      chk(n_rd == r0 && n_wr == w0, "R7 upgrade no memory", 64'(n_rd + n_wr), 64'(r0 + w0));
      chk(lat == W + 1, "R9 upgrade latency", 64'(lat), 64'(W + 1));
      chk(sh == 1'b1, "R4 shared on upgrade", 64'(sh), 64'd1);
      snp_hit = '0;
   endtask

   task automatic t_wb();
      logic sh; logic [DW-1:0] d; int lat; int w0;
      w0 = n_wr;
      do_txn(1, 2'd3, 16'h0500, 32'hCAFE_F00D, sh, d, lat);
      chk(n_wr == w0 + 1, "R8 one memory write", 64'(n_wr), 64'(w0 + 1));
      chk(wr_addr_seen == 16'h0500, "R8 write address", 64'(wr_addr_seen), 64'h0500);
      chk(wr_data_seen == 32'hCAFE_F00D, "R8 write data", 64'(wr_data_seen), 64'hCAFEF00D);
      chk(lat > W, "R8 done after ack", 64'(lat), 64'(W + 1));
   endtask

   task automatic t_early_mem();
      logic sh; logic [DW-1:0] d; int lat;
      mem_lat = 0;
      snp_hit = '0; snp_dirty = '0;
      do_txn(2, 2'd1, 16'h0610, '0, sh, d, lat);
      chk(d == mem_pat(16'h0610), "R6 early memory answer", 64'(d), 64'(mem_pat(16'h0610)));
      mem_lat = 4;
   endtask

   task automatic t_round_robin();
      // previous owner is cache 2, so order for requesters {0,1,3} is 3,0,1
      int order[3];
      int got = 0;
      int multi = 0;
      @(negedge clk);
      snp_hit = '0; snp_dirty = '0;
      for (int k = 0; k < N; k++) begin
         req_type[k*2 +: 2]   = 2'd0;
         req_addr[k*AW +: AW] = AW'(16'h0700 + k);
      end
      req_valid = 4'b1011;
      while (got < 3) begin
         @(negedge clk);
         if (!$onehot0(grant)) multi++;
         if (|resp_done) begin
            for (int k = 0; k < N; k++) begin
               if (resp_done[k]) begin
                  order[got] = k;
                  req_valid[k] = 1'b0;
               end
            end
            got++;
         end
      end
      chk(order[0] == 3, "R2 first winner", 64'(order[0]), 64'd3);
      chk(order[1] == 0, "R2 second winner", 64'(order[1]), 64'd0);
      chk(order[2] == 1, "R2 third winner", 64'(order[2]), 64'd1);
      chk(multi == 0, "R1 single grant", 64'(multi), 64'd0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rd_alone();
      t_rd_shared();
      t_intervene();
      t_upgr();
      t_wb();
      t_early_mem();
      t_round_robin();
      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      #(5 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

endmodule